// File: doc/BRIEF.md
# Timer Input Capture Channel

This block timestamps events on one asynchronous input pin. The pin passes through a two-flop synchronizer. A third register holds the sample from one clock earlier, and comparing the two gives rising and falling edges. A programmable mode decides which edges count as a capture event: falling edges only, rising edges only, both polarities, or every 4th or every 16th rising edge.

On each capture event the block stores the full value of one of two external free-running timer buses in a four-entry FIFO. A select bit picks which bus is stored. Software reads the oldest entry with a read strobe, which also removes it. Status outputs show whether the buffer holds data and whether a capture was lost. A sticky interrupt flag rises once the buffer holds a programmable number of entries.

Configuration is a single write port. Each write loads the mode, the timer select and the threshold. The same write can also clear the interrupt flag.

Top module: `tcap_channel`

## Requirements
- R1: After reset, `buf_ne`, `ovf` and `irq` are 0, `rd_data` is 0 and the mode is off.
- R2: Mode 010 captures on every falling edge of the pin and ignores rising edges.
- R3: Mode 011 captures on every rising edge of the pin and ignores falling edges.
- R4: Mode 001 captures on every edge of either polarity.
- R5: Mode 100 captures on every 4th rising edge, counted from the moment the mode was entered.
- R6: Mode 101 captures on every 16th rising edge, counted from the moment the mode was entered.
- R7: Modes 000, 110 and 111 are off. While off, no capture is taken, the rising-edge count is cleared and `ovf` is cleared.
- R8: Bit 3 of `cfg_wdata` selects the timer. A value of 1 stores `tmr_a` and a value of 0 stores `tmr_b`. Mode is bits 2:0.
- R9: The FIFO holds 4 entries. `rd_data` shows the oldest entry, or 0 when the FIFO is empty. A read strobe removes that entry. `buf_ne` is 1 while any entry is held.
- R10: A capture that arrives while 4 entries are held is dropped and sets `ovf`. `ovf` stays set until the FIFO is read empty or the mode is turned off.
- R11: Bits 6:5 of `cfg_wdata` set the threshold; 00 means 1 entry and 11 means 4 entries. `irq` rises when a capture brings the fill level to at least the threshold, and then stays set.
- R12: A write with bit 4 of `cfg_wdata` set clears `irq`. Only a later capture that meets the threshold sets it again.
- R13: A write that changes the mode restarts the rising-edge count used by modes 100 and 101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_async | input | 1 | Asynchronous event pin |
| tmr_a | input | 16 | First timer bus (select bit 1) |
| tmr_b | input | 16 | Second timer bus (select bit 0) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Mode [2:0], timer select [3], irq clear [4], threshold [6:5] |
| rd_en | input | 1 | Read strobe; removes the oldest entry |
| rd_data | output | 16 | Oldest entry, or 0 when empty |
| buf_ne | output | 1 | Buffer holds at least one entry |
| ovf | output | 1 | A capture was lost to a full buffer |
| irq | output | 1 | Sticky threshold interrupt flag |

## Verification
The assertions check these rules on every cycle:
- An off mode never yields an event and clears overflow.
- The fill level never exceeds the depth.
- A full buffer keeps its level when a capture arrives without a read, and overflow rises only on such a drop.
- The interrupt flag holds until a clear.
- A clear without a simultaneous capture lowers the flag.
- Reading the last entry clears not-empty and overflow.

Only the directed scenarios can show the following:
- Which edge polarity each mode accepts.
- The 4th and 16th rising-edge counting and its restart when the mode changes.
- The timer select.
- The first-in first-out order of stored values.
- The exact fill level at which each threshold raises the flag.

// File: rtl/tcap_pkg.sv
`timescale 1ns/1ps
package tcap_pkg;
   typedef enum logic [2:0] {
      MODE_OFF    = 3'b000,
      MODE_ANY    = 3'b001,
      MODE_FALL   = 3'b010,
      MODE_RISE   = 3'b011,
      MODE_DIV_LO = 3'b100,
      MODE_DIV_HI = 3'b101,
      MODE_RSV6   = 3'b110,
      MODE_RSV7   = 3'b111
   } mode_e;

   localparam int CFG_MODE_LSB = 0;
   localparam int CFG_TSEL_BIT = 3;
   localparam int CFG_CLR_BIT  = 4;
   localparam int CFG_THR_LSB  = 5;

   function automatic logic mode_active(mode_e m);
      return (m == MODE_ANY) || (m == MODE_FALL) || (m == MODE_RISE) ||
             (m == MODE_DIV_LO) || (m == MODE_DIV_HI);
   endfunction
endpackage

// File: rtl/tcap_edge.sv
`timescale 1ns/1ps
module tcap_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcap_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], pin_async};
         prev  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/tcap_qualify.sv
`timescale 1ns/1ps
module tcap_qualify
   import tcap_pkg::*;
#(
   parameter int PRE_LO = 4,
   parameter int PRE_HI = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  mode_e mode,
   input  logic  rise,
   input  logic  fall,
   input  logic  clr,
   output logic  evt
);
   localparam int PRE_MAX = (PRE_LO > PRE_HI) ? PRE_LO : PRE_HI;
   localparam int PCW     = $clog2(PRE_MAX);

   generate
      if (PRE_LO < 2 || PRE_HI < 2) begin : g_bad_pre
         $error("tcap_qualify: prescale ratios must be at least 2");
      end
   endgenerate

   logic [PCW-1:0] cnt;
   logic           div_mode;

   assign div_mode = (mode == MODE_DIV_LO) || (mode == MODE_DIV_HI);

   always_comb begin
      case (mode)
         MODE_ANY:    evt = rise | fall;
         MODE_FALL:   evt = fall;
         MODE_RISE:   evt = rise;
         MODE_DIV_LO: evt = rise && (cnt == PCW'(PRE_LO - 1));
         MODE_DIV_HI: evt = rise && (cnt == PCW'(PRE_HI - 1));
         default:     evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (rise && div_mode) begin
         if (evt) cnt <= '0;
         else     cnt <= cnt + PCW'(1);
      end
   end
endmodule

// File: rtl/tcap_fifo.sv
`timescale 1ns/1ps
module tcap_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic [W-1:0]               wdata,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("tcap_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp;
   logic [PW-1:0] rp;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + PW'(1);
         if (pop)  rp <= rp + PW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign rdata = (count == '0) ? '0 : mem[rp];
endmodule

// File: rtl/tcap_channel.sv
`timescale 1ns/1ps
module tcap_channel
   import tcap_pkg::*;
#(
   parameter int TMR_W       = 16,
   parameter int FIFO_DEPTH  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int PRESCALE_LO = 4,
   parameter int PRESCALE_HI = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 pin_async,
   input  logic [TMR_W-1:0]                     tmr_a,
   input  logic [TMR_W-1:0]                     tmr_b,
   input  logic                                 cfg_we,
   input  logic [CFG_THR_LSB+$clog2(FIFO_DEPTH)-1:0] cfg_wdata,
   input  logic                                 rd_en,
   output logic [TMR_W-1:0]                     rd_data,
   output logic                                 buf_ne,
   output logic                                 ovf,
   output logic                                 irq
);
   localparam int THR_W = $clog2(FIFO_DEPTH);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (TMR_W < 1) begin : g_bad_width
         $error("tcap_channel: TMR_W must be positive");
      end
   endgenerate

   mode_e            mode_q;
   logic             tsel_q;
   logic [THR_W-1:0] thr_q;
   mode_e            wr_mode;
   logic             irq_clr;
   logic             mode_off;
   logic             mode_chg;
   logic             rise;
   logic             fall;
   logic             cap_evt;
   logic [TMR_W-1:0] sel_val;
   logic [CNT_W-1:0] fifo_cnt;
   logic [CNT_W-1:0] cnt_next;
   logic             full;
   logic             push_ok;
   logic             pop_ok;

   assign wr_mode  = mode_e'(cfg_wdata[CFG_MODE_LSB +: 3]);
   assign irq_clr  = cfg_wdata[CFG_CLR_BIT];
   assign mode_off = !mode_active(mode_q);
   assign mode_chg = cfg_we && (wr_mode != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_OFF;
         tsel_q <= 1'b0;
         thr_q  <= '0;
      end else if (cfg_we) begin
         mode_q <= wr_mode;
         tsel_q <= cfg_wdata[CFG_TSEL_BIT];
         thr_q  <= cfg_wdata[CFG_THR_LSB +: THR_W];
      end
   end

   tcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_async),
      .rise      (rise),
      .fall      (fall)
   );

   tcap_qualify #(.PRE_LO(PRESCALE_LO), .PRE_HI(PRESCALE_HI)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q),
      .rise  (rise),
      .fall  (fall),
      .clr   (mode_off || mode_chg),
      .evt   (cap_evt)
   );

   assign sel_val = tsel_q ? tmr_a : tmr_b;
   assign full    = (fifo_cnt == CNT_W'(FIFO_DEPTH));
   assign pop_ok  = rd_en && (fifo_cnt != '0);
   assign push_ok = cap_evt && (!full || pop_ok);
   assign cnt_next = fifo_cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);

   tcap_fifo #(.W(TMR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .pop   (pop_ok),
      .wdata (sel_val),
      .rdata (rd_data),
      .count (fifo_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (mode_off) begin
         ovf <= 1'b0;
      end else if (cap_evt && !push_ok) begin
         ovf <= 1'b1;
      end else if (pop_ok && !push_ok && fifo_cnt == CNT_W'(1)) begin
         ovf <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (push_ok && (cnt_next >= CNT_W'(thr_q) + CNT_W'(1))) begin
         irq <= 1'b1;
      end else if (cfg_we && irq_clr) begin
         irq <= 1'b0;
      end
   end

   assign buf_ne = (fifo_cnt != '0);
endmodule

// File: rtl/tcap_channel_chk.sv
`timescale 1ns/1ps
module tcap_channel_chk #(
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    mode,
   input logic          cap_evt,
   input logic          push_ok,
   input logic          pop_ok,
   input logic [CW-1:0] count,
   input logic          ovf,
   input logic          irq,
   input logic          cfg_we,
   input logic          irq_clr,
   input logic          buf_ne
);
   logic is_off;
   assign is_off = (mode == 3'b000) || (mode == 3'b110) || (mode == 3'b111);

   AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      is_off |-> !cap_evt); // R7
   AST_OFF_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      is_off |=> !ovf); // R7
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R9
   AST_LAST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && count == CW'(1) && !push_ok) |=> (!buf_ne && !ovf)); // R10
   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && count == CW'(DEPTH) && !pop_ok) |=> (count == CW'(DEPTH) && ovf)); // R10
   AST_OVF_ONLY_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> ($past(count) == CW'(DEPTH) && $past(cap_evt))); // R10
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(cfg_we && irq_clr)) |=> irq); // R11
   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && irq_clr && !push_ok) |=> !irq); // R12
endmodule

bind tcap_channel tcap_channel_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode    (mode_q),
   .cap_evt (cap_evt),
   .push_ok (push_ok),
   .pop_ok  (pop_ok),
   .count   (fifo_cnt),
   .ovf     (ovf),
   .irq     (irq),
   .cfg_we  (cfg_we),
   .irq_clr (irq_clr),
   .buf_ne  (buf_ne)
);

// File: tb/tcap_channel_tb.sv
`timescale 1ns/1ps
module tcap_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_async = 1'b0;
   logic [15:0] tmr_a = '0;
   logic [15:0] tmr_b = '0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_wdata = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic        buf_ne;
   logic        ovf;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tcap_channel dut_i (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
      .tmr_a(tmr_a), .tmr_b(tmr_b),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rd_en(rd_en),
      .rd_data(rd_data), .buf_ne(buf_ne), .ovf(ovf), .irq(irq)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // cfg_wdata layout: mode [2:0], tsel [3], irq clear [4], threshold [6:5]
   task automatic cfg(logic [2:0] mode, logic tsel, logic [1:0] thr, logic clr);
      cfg_wdata = {thr, clr, tsel, mode};
      cfg_we    = 1'b1;
      cyc(1);
      cfg_we    = 1'b0;
   endtask

   task automatic set_pin(logic v);
      pin_async = v;
      cyc(4);
   endtask

   task automatic pop_chk(string req, int exp);
      chk(req, "buf_ne before read", int'(buf_ne), 1);
      chk(req, "rd_data", int'(rd_data), exp);
      rd_en = 1'b1;
      cyc(1);
      rd_en = 1'b0;
   endtask

   task automatic empty_chk(string req);
      chk(req, "buf_ne empty", int'(buf_ne), 0);
      chk(req, "rd_data empty", int'(rd_data), 0);
   endtask

   task automatic clean();
      cfg(3'b000, 1'b0, 2'b00, 1'b1);
      set_pin(1'b0);
      rd_en = 1'b1;
      cyc(5);
      rd_en = 1'b0;
      cyc(1);
   endtask

   task automatic t_reset();
      chk("R1", "buf_ne", int'(buf_ne), 0);
      chk("R1", "ovf", int'(ovf), 0);
      chk("R1", "irq", int'(irq), 0);
      chk("R1", "rd_data", int'(rd_data), 0);
      set_pin(1'b1);
      set_pin(1'b0);
      chk("R1", "reset mode off, no capture", int'(buf_ne), 0);
   endtask

   task automatic t_rising();
      clean();
      tmr_a = 16'h1111; tmr_b = 16'h2222;
      cfg(3'b011, 1'b1, 2'b00, 1'b0);
      set_pin(1'b1);
      chk("R11", "irq at threshold 1", int'(irq), 1);
      set_pin(1'b0);
      pop_chk("R3", 16'h1111);
      empty_chk("R3");
      cfg(3'b011, 1'b1, 2'b00, 1'b1);
      chk("R12", "irq cleared", int'(irq), 0);
   endtask

   task automatic t_falling();
      clean();
      tmr_a = 16'h3333; tmr_b = 16'h4444;
      cfg(3'b010, 1'b0, 2'b00, 1'b0);
      set_pin(1'b1);
      chk("R2", "rising ignored", int'(buf_ne), 0);
      set_pin(1'b0);
      pop_chk("R8", 16'h4444);
      empty_chk("R2");
   endtask

   task automatic t_both();
      clean();
      cfg(3'b001, 1'b1, 2'b11, 1'b0);
      tmr_a = 16'hA001; set_pin(1'b1);
      tmr_a = 16'hA002; set_pin(1'b0);
      pop_chk("R4", 16'hA001);
      pop_chk("R4", 16'hA002);
      empty_chk("R4");
   endtask

   task automatic t_div(logic [2:0] mode, int ratio, string req);
      clean();
      cfg(mode, 1'b1, 2'b11, 1'b0);
      for (int i = 1; i <= 2 * ratio; i++) begin
         tmr_a = 16'(i);
         set_pin(1'b1);
         set_pin(1'b0);
         if (i == ratio - 1) chk(req, "no capture before ratio", int'(buf_ne), 0);
      end
      pop_chk(req, ratio);
      pop_chk(req, 2 * ratio);
      empty_chk(req);
   endtask

   task automatic t_mode_change();
      clean();
      cfg(3'b100, 1'b1, 2'b00, 1'b0);
      for (int i = 0; i < 3; i++) begin
         set_pin(1'b1); set_pin(1'b0);
      end
      cfg(3'b011, 1'b1, 2'b00, 1'b0);
      cfg(3'b100, 1'b1, 2'b00, 1'b0);
      for (int i = 0; i < 3; i++) begin
         set_pin(1'b1); set_pin(1'b0);
      end
      chk("R13", "count restarted", int'(buf_ne), 0);
      tmr_a = 16'hABCD;
      set_pin(1'b1); set_pin(1'b0);
      pop_chk("R13", 16'hABCD);
   endtask

   task automatic t_off();
      logic [2:0] offs [3] = '{3'b000, 3'b110, 3'b111};
      clean();
      foreach (offs[k]) begin
         cfg(offs[k], 1'b1, 2'b00, 1'b0);
         set_pin(1'b1);
         set_pin(1'b0);
         chk("R7", "off mode no capture", int'(buf_ne), 0);
      end
   endtask

   task automatic t_overflow();
      clean();
      cfg(3'b001, 1'b1, 2'b11, 1'b0);
      for (int i = 0; i < 5; i++) begin
         tmr_a = 16'h100 + 16'(i);
         set_pin(~pin_async);
         if (i == 2) chk("R11", "irq below threshold 4", int'(irq), 0);
         if (i == 3) begin
            chk("R11", "irq at threshold 4", int'(irq), 1);
            chk("R10", "ovf before drop", int'(ovf), 0);
         end
      end
      chk("R10", "ovf after drop", int'(ovf), 1);
      pop_chk("R9", 16'h100);
      pop_chk("R9", 16'h101);
      pop_chk("R9", 16'h102);
      chk("R10", "ovf held", int'(ovf), 1);
      pop_chk("R10", 16'h103);
      chk("R10", "ovf cleared on empty", int'(ovf), 0);
      empty_chk("R10");
   endtask

   task automatic t_ovf_off();
      clean();
      cfg(3'b001, 1'b0, 2'b00, 1'b0);
      for (int i = 0; i < 5; i++) set_pin(~pin_async);
      chk("R10", "ovf set", int'(ovf), 1);
      cfg(3'b000, 1'b0, 2'b00, 1'b0);
      cyc(1);
      chk("R7", "ovf cleared by off", int'(ovf), 0);
      chk("R7", "entries kept while off", int'(buf_ne), 1);
   endtask

   task automatic t_irq_clear();
      clean();
      cfg(3'b011, 1'b1, 2'b01, 1'b0);
      tmr_a = 16'h0051; set_pin(1'b1); set_pin(1'b0);
      chk("R11", "irq below threshold 2", int'(irq), 0);
      tmr_a = 16'h0052; set_pin(1'b1); set_pin(1'b0);
      chk("R11", "irq at threshold 2", int'(irq), 1);
      cfg(3'b011, 1'b1, 2'b01, 1'b1);
      chk("R12", "irq cleared", int'(irq), 0);
      pop_chk("R12", 16'h0051);
      cyc(3);
      chk("R12", "no rearm without capture", int'(irq), 0);
      tmr_a = 16'h0053; set_pin(1'b1); set_pin(1'b0);
      chk("R12", "rearmed by capture", int'(irq), 1);
      pop_chk("R12", 16'h0052);
      pop_chk("R12", 16'h0053);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_rising();
      t_falling();
      t_both();
      t_div(3'b100, 4, "R5");
      t_div(3'b101, 16, "R6");
      t_mode_change();
      t_off();
      t_overflow();
      t_ovf_off();
      t_irq_clear();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule